// File: doc/BRIEF.md
# Per-Core Countdown Interrupt Timer

This block is a countdown timer for a single processor core. Software programs a control word that holds an interrupt vector, a delivery mode, a trigger mode, a mask flag and a one-shot/periodic flag. Writing the start-count register loads the live counter and starts it. The counter then drops by one on each clock cycle in which the tick-enable input is high. The tick input is produced outside this block from a configurable divided clock, so it sets the timer period.

When the counter moves from one to zero, the timer has expired. If the mask flag is clear, the block emits a request that carries the vector, mode and trigger fields of the control word. In periodic mode the counter is then reloaded from the start count, whether or not the request was masked. In one-shot mode the counter stays at zero.

The request output is a one-cycle strobe with no ready input. The consumer must take it in the cycle it is high, and the block never holds it back. The register port has a write side and a separate, combinational read side, and both are plain control pins.

Top module: `lapic_timer`

## Requirements
- R1: After reset the control word reads 0x0001_0000 (mask set), the start count and the live count both read zero, and no request is driven.
- R2: A write with select 0 stores the start count and loads the same value into the live count. Select 0 reads back the start count.
- R3: The live count (read with select 1) drops by exactly one on each cycle with tick-enable high and a non-zero count. Without tick-enable it holds its value.
- R4: When the count expires with mask bit 16 clear, the request is high for the following cycle only. It carries vector = control bits 7:0, mode = bits 10:8 and level = bit 15, all taken from the control word in force at expiry.
- R5: When the count expires with mask bit 16 set, no request is driven.
- R6: With periodic bit 17 set, expiry reloads the live count from the start count, whether or not the entry is masked.
- R7: With bit 17 clear, the live count stays at zero after expiry and no further request follows.
- R8: Writing a start count of zero stops the timer at zero without a request.
- R9: Writes with select 1 have no effect. The live count is read-only.
- R10: A write with select 2 stores bits 17:0 of the data. Select 2 reads those bits back with bits 31:18 as zero. Select 3 reads zero.
- R11: A start-count write takes priority over a tick in the same cycle. The count becomes the written value, and no expiry occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer tick strobe; one decrement per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write select: 0 start count, 1 live count (ignored), 2 control word |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 2 | Read select: 0 start count, 1 live count, 2 control word, 3 zero |
| reg_rdata | output | 32 | Combinational read data |
| req_valid | output | 1 | One-cycle interrupt request strobe |
| req_vector | output | 8 | Vector carried by the request |
| req_mode | output | 3 | Delivery mode carried by the request |
| req_level | output | 1 | Trigger mode carried by the request (1 = level) |

## Verification
A corrupted live count shows up on the read port in the same cycle. It also moves the request strobe earlier or later by the size of the error, so the expiry timing checks against the model catch it at the next expiry. If the mask or periodic flag is wrong, the error appears within one period: an expiry produces a request when it should be silent, or stays silent when it should post, or the count reloads instead of stopping. The bench compares a read-back value and the request fields with its model on every cycle, so any difference is reported in the cycle it first becomes visible.

// File: rtl/lapic_timer_pkg.sv
package lapic_timer_pkg;
  localparam int CTL_W      = 18;
  localparam int VEC_LO     = 0;
  localparam int VEC_W      = 8;
  localparam int MODE_LO    = 8;
  localparam int MODE_W     = 3;
  localparam int LEVEL_BIT  = 15;
  localparam int MASK_BIT   = 16;
  localparam int PERIOD_BIT = 17;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_LIVE  = 2'd1,
    SEL_CTL   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [MODE_W-1:0] mode;
    logic              level;
  } req_fields_t;
endpackage

// File: rtl/lapic_timer_ctl.sv
module lapic_timer_ctl
  import lapic_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CTL_W-1:0]  ctl_word,
  output req_fields_t       fields,
  output logic              masked,
  output logic              periodic
);
  localparam logic [CTL_W-1:0] CTL_RESET = CTL_W'(1) << MASK_BIT;

  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     ctl_q <= CTL_RESET;
    else if (wr_en) ctl_q <= wr_data[CTL_W-1:0];
  end

  assign ctl_word      = ctl_q;
  assign fields.vector = ctl_q[VEC_LO +: VEC_W];
  assign fields.mode   = ctl_q[MODE_LO +: MODE_W];
  assign fields.level  = ctl_q[LEVEL_BIT];
  assign masked        = ctl_q[MASK_BIT];
  assign periodic      = ctl_q[PERIOD_BIT];

  assert_reset_masked_R1: assert property (@(posedge clk)
    !rst_n |=> masked);
endmodule

// File: rtl/lapic_timer_count.sv
module lapic_timer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] start_cnt,
  output logic [CNT_W-1:0] live_cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] start_q, live_q;
  logic             running;

  assign running = tick && !load && (live_q != '0);
  assign expire  = running && (live_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      live_q  <= '0;
    end else if (load) begin
      start_q <= load_val;
      live_q  <= load_val;
    end else if (expire) begin
      live_q  <= periodic ? start_q : '0;
    end else if (running) begin
      live_q  <= live_q - ONE;
    end
  end

  assign start_cnt = start_q;
  assign live_cnt  = live_q;

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && live_q > ONE) |=> live_q == $past(live_q) - ONE);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(live_q));

  assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic) |=> live_q == '0);

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> live_q == start_q);

  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> live_q == $past(load_val));
endmodule

// File: rtl/lapic_timer_req.sv
module lapic_timer_req
  import lapic_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        expire,
  input  logic        masked,
  input  req_fields_t fields_in,
  output logic        valid,
  output req_fields_t fields_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid      <= 1'b0;
      fields_out <= '0;
    end else begin
      valid <= expire && !masked;
      if (expire && !masked) fields_out <= fields_in;
    end
  end
endmodule

// File: rtl/lapic_timer.sv
module lapic_timer
  import lapic_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [1:0]        reg_rsel,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              req_valid,
  output logic [VEC_W-1:0]  req_vector,
  output logic [MODE_W-1:0] req_mode,
  output logic              req_level
);
  logic [CTL_W-1:0] ctl_word;
  req_fields_t      ctl_fields, req_fields;
  logic             masked, periodic, expire, load;
  logic [CNT_W-1:0] start_cnt, live_cnt;

  assign load = reg_wr && (reg_sel == SEL_START);

  lapic_timer_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr && (reg_sel == SEL_CTL)),
    .wr_data(reg_wdata),
    .ctl_word(ctl_word), .fields(ctl_fields),
    .masked(masked), .periodic(periodic)
  );

  lapic_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_val(reg_wdata[CNT_W-1:0]),
    .tick(tick_en), .periodic(periodic),
    .start_cnt(start_cnt), .live_cnt(live_cnt), .expire(expire)
  );

  lapic_timer_req u_req (
    .clk(clk), .rst_n(rst_n),
    .expire(expire), .masked(masked),
    .fields_in(ctl_fields),
    .valid(req_valid), .fields_out(req_fields)
  );

  always_comb begin
    unique case (reg_rsel)
      SEL_START: reg_rdata = DATA_W'(start_cnt);
      SEL_LIVE:  reg_rdata = DATA_W'(live_cnt);
      SEL_CTL:   reg_rdata = DATA_W'(ctl_word);
      default:   reg_rdata = '0;
    endcase
  end

  assign req_vector = req_fields.vector;
  assign req_mode   = req_fields.mode;
  assign req_level  = req_fields.level;

  assert_masked_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !$past(masked));

  assert_req_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(tick_en) && !$past(load));

  assert_zero_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && reg_wdata[CNT_W-1:0] == '0) |=> !req_valid && live_cnt == '0);
endmodule

// File: tb/lapic_timer_tb.sv
`timescale 1ns/1ps
module lapic_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [1:0]  reg_rsel = 2'd0;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic [7:0]  req_vector;
  logic [2:0]  req_mode;
  logic        req_level;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string phase = "R1";

  longint unsigned m_start, m_live, m_ctl;
  bit m_req;
  int m_vec, m_mode, m_lvl;

  always #2.5 clk = ~clk;

  lapic_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_vector(req_vector),
    .req_mode(req_mode), .req_level(req_level)
  );

  task automatic check(input string what, input longint unsigned act, input longint unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h t=%0t", phase, what, act, exp, $time);
    end
  endtask

  function automatic longint unsigned model_read(input int sel);
    case (sel)
      0: return m_start;
      1: return m_live;
      2: return m_ctl;
      default: return 0;
    endcase
  endfunction

  // Compare at the current cycle, then drive the next inputs and advance the model.
  task automatic step(input bit wr, input int sel, input longint unsigned data,
                      input bit tick, input int rsel);
    @(negedge clk);
    reg_rsel = 2'(rsel);
    #0.5;
    check("rdata", reg_rdata, model_read(rsel));
    check("req_valid", req_valid, m_req);
    if (m_req) begin
      check("req_vector", req_vector, m_vec);
      check("req_mode", req_mode, m_mode);
      check("req_level", req_level, m_lvl);
    end
    reg_wr = wr; reg_sel = 2'(sel); reg_wdata = 32'(data); tick_en = tick;
    m_req = 0;
    if (wr && sel == 0) begin
      m_start = data & 32'hFFFF_FFFF;
      m_live  = m_start;
    end else if (tick && m_live != 0) begin
      if (m_live == 1) begin
        if (((m_ctl >> 16) & 1) == 0) begin
          m_req  = 1;
          m_vec  = int'(m_ctl & 8'hFF);
          m_mode = int'((m_ctl >> 8) & 3'h7);
          m_lvl  = int'((m_ctl >> 15) & 1);
        end
        m_live = (((m_ctl >> 17) & 1) != 0) ? m_start : 0;
      end else begin
        m_live = m_live - 1;
      end
    end
    if (wr && sel == 2) m_ctl = data & 18'h3FFFF;
  endtask

  task automatic run(input int n, input bit tick);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, tick, i % 3);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_start = 0; m_live = 0; m_ctl = 32'h1_0000; m_req = 0;
    m_vec = 0; m_mode = 0; m_lvl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    phase = "R1";
    step(0, 0, 0, 0, 2); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 3);

    phase = "R10";
    step(1, 2, 32'hFFFF_FFFF, 0, 2); step(0, 0, 0, 0, 2); step(0, 0, 0, 0, 3);

    phase = "R4_R7";
    step(1, 2, 32'h0000_8341, 0, 2);
    step(1, 0, 5, 0, 0);
    step(0, 0, 0, 0, 1);
    run(8, 1'b1);
    phase = "R3";
    step(1, 0, 4, 0, 1);
    for (int i = 0; i < 12; i++) step(0, 0, 0, (i % 3) == 0, 1);

    phase = "R5_R6";
    step(1, 2, 32'h0003_00A7, 0, 2);
    step(1, 0, 3, 0, 1);
    run(12, 1'b1);

    phase = "R6";
    step(1, 2, 32'h0002_0522, 0, 2);
    step(1, 0, 2, 0, 1);
    for (int i = 0; i < 14; i++) step(0, 0, 0, i[0], 1);

    phase = "R8";
    step(1, 0, 6, 1, 1);
    run(3, 1'b1);
    step(1, 0, 0, 1, 1);
    run(6, 1'b1);

    phase = "R9";
    step(1, 0, 9, 0, 1);
    step(1, 1, 32'h55, 1, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);

    phase = "R11";
    step(1, 0, 1, 0, 1);
    step(1, 0, 7, 1, 1);
    step(0, 0, 0, 0, 1);
    step(1, 0, 1, 0, 1);
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1);

    phase = "R2_R4_mix";
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 19);
      if (r == 0)      step(1, 0, $urandom_range(0, 6), $urandom_range(0, 1), $urandom_range(0, 3));
      else if (r == 1) step(1, 2, $urandom, $urandom_range(0, 1), $urandom_range(0, 3));
      else if (r == 2) step(1, 1, $urandom, $urandom_range(0, 1), $urandom_range(0, 3));
      else             step(0, 0, 0, $urandom_range(0, 3) != 0, $urandom_range(0, 3));
    end

    step(0, 0, 0, 0, 1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule